// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32.768 kHz tick enable into periodic event pulses for a real-time-clock status path. A 4-bit rate code selects a power-of-two period, measured in ticks. Each event is a one-cycle pulse: the periodic-flag event always fires, the interrupt request fires only when interrupts are enabled, and a square-wave pulse fires only when that output is enabled.

Events are not timed from the moment of programming. A free-running tick counter sets the phase, and an event fires on every tick that brings the counter to a multiple of the selected period. Changing the rate code or either enable never resets this counter. After a change, the next event therefore lands on the first multiple of the new period that follows the current count.

All pins are plain control and event signals, sampled and driven on the rising clock edge. No handshake is involved.

Top module: `rtc_rate_gen`

## Requirements
- R1: During and directly after reset, all three event outputs are low, and the tick counter restarts from 0.
- R2: Rate code 0 stops the generator, and no output ever pulses.
- R3: For rate codes 3 to 15, the period is 2^(code-1) ticks. Code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R4: Rate code 1 gives the same period as code 8 (128 ticks), and rate code 2 gives the same period as code 9 (256 ticks).
- R5: When both `irq_enable` and `sqw_enable` are low, the generator stops and `pf_pulse` stays low, whatever the rate code.
- R6: An event fires on the clock edge of a tick that makes the 15-bit free-running tick count (ticks since reset, modulo 32768) a multiple of the period. The count keeps running while the generator is stopped or reprogrammed.
- R7: `irq_pulse` pulses together with `pf_pulse` only when `irq_enable` is high, and it never pulses without `pf_pulse`.
- R8: `sqw_pulse` pulses together with `pf_pulse` only when `sqw_enable` is high, and it never pulses without `pf_pulse`.
- R9: Every event is a single-cycle pulse, and it appears only in the cycle after an edge at which `tick_en` was high.
- R10: After the rate code changes while running, the next event is the first multiple of the new period after the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle strobe for each 32.768 kHz tick |
| rate_code | input | 4 | Period selection code; 0 stops the generator |
| irq_enable | input | 1 | Periodic interrupt enable |
| sqw_enable | input | 1 | Square-wave pulse enable |
| pf_pulse | output | 1 | Periodic event pulse to the status logic |
| irq_pulse | output | 1 | Interrupt request pulse |
| sqw_pulse | output | 1 | Square-wave output pulse |

## Verification
The bench uses the default 15-bit tick counter and raises `tick_en` in most cycles. Within the run, the count therefore wraps through 32768 more than once, so alignment at the wrap point and the longest period (code 15) are both checked. Short periods and the aliased codes 1 and 2 are exercised with reprogramming in mid-period. This shows that the phase survives rate and enable changes.

// File: rtl/rtc_rate_pkg.sv
package rtc_rate_pkg;
  localparam int CODE_W = 4;
  localparam int EXP_W  = 5;

  // Exponent of the period in ticks; codes 1 and 2 reuse the slow settings.
  function automatic logic [EXP_W-1:0] rate_exponent(input logic [CODE_W-1:0] code);
    logic [EXP_W-1:0] eff;
    case (code)
      4'd1:    eff = 5'd8;
      4'd2:    eff = 5'd9;
      default: eff = {1'b0, code};
    endcase
    return eff - 5'd1;
  endfunction
endpackage

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt_next
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_next = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_next;
  end
endmodule

// File: rtl/rtc_rate_decode.sv
module rtc_rate_decode
  import rtc_rate_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic [CODE_W-1:0] rate_code,
  input  logic              irq_enable,
  input  logic              sqw_enable,
  output logic              active,
  output logic [CNT_W-1:0]  align_mask
);
  logic [EXP_W-1:0] exp_w;

  assign exp_w  = rate_exponent(rate_code);
  assign active = (rate_code != '0) && (irq_enable || sqw_enable);

  // Low bits that must be zero at an aligned boundary.
  for (genvar g = 0; g < CNT_W; g++) begin : g_mask
    assign align_mask[g] = (32'(g) < 32'(exp_w));
  end
endmodule

// File: rtl/rtc_event_gen.sv
module rtc_event_gen #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             active,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic [CNT_W-1:0] align_mask,
  input  logic             irq_enable,
  input  logic             sqw_enable,
  output logic             pf_q,
  output logic             irq_q,
  output logic             sqw_q
);
  logic hit;

  assign hit = tick_en && active && ((cnt_next & align_mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_q  <= 1'b0;
      irq_q <= 1'b0;
      sqw_q <= 1'b0;
    end else begin
      pf_q  <= hit;
      irq_q <= hit && irq_enable;
      sqw_q <= hit && sqw_enable;
    end
  end

  assert_pf_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pf_q |-> $past(tick_en));
  assert_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pf_q |=> !pf_q);
endmodule

// File: rtl/rtc_rate_gen.sv
module rtc_rate_gen
  import rtc_rate_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              irq_enable,
  input  logic              sqw_enable,
  output logic              pf_pulse,
  output logic              irq_pulse,
  output logic              sqw_pulse
);
  logic [CNT_W-1:0] cnt_next;
  logic [CNT_W-1:0] align_mask;
  logic             active;

  rtc_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_next(cnt_next)
  );

  rtc_rate_decode #(.CNT_W(CNT_W)) u_dec (
    .rate_code(rate_code), .irq_enable(irq_enable), .sqw_enable(sqw_enable),
    .active(active), .align_mask(align_mask)
  );

  rtc_event_gen #(.CNT_W(CNT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .active(active),
    .cnt_next(cnt_next), .align_mask(align_mask),
    .irq_enable(irq_enable), .sqw_enable(sqw_enable),
    .pf_q(pf_pulse), .irq_q(irq_pulse), .sqw_q(sqw_pulse)
  );

  assert_irq_implies_pf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> pf_pulse);
  assert_sqw_implies_pf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_pulse |-> pf_pulse);
  assert_code_zero_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pf_pulse |-> ($past(rate_code) != '0));
  assert_enable_needed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pf_pulse |-> ($past(irq_enable) || $past(sqw_enable)));
endmodule

// File: tb/rtc_rate_gen_test.sv
module rtc_rate_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       irq_enable = 1'b0;
  logic       sqw_enable = 1'b0;
  logic       pf_pulse, irq_pulse, sqw_pulse;

  int unsigned tests = 0;
  int unsigned fails = 0;
  int unsigned mcnt = 0;
  int unsigned pf_seen = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  rtc_rate_gen uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_code(rate_code),
    .irq_enable(irq_enable), .sqw_enable(sqw_enable),
    .pf_pulse(pf_pulse), .irq_pulse(irq_pulse), .sqw_pulse(sqw_pulse)
  );

  function automatic int unsigned period_of(input logic [3:0] c);
    int e;
    e = (c == 4'd1) ? 8 : (c == 4'd2) ? 9 : int'(c);
    return 32'd1 << (e - 1);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b (count %0d code %0d)",
               req, act, exp, mcnt, rate_code);
    end
  endtask

  // One cycle: drive at negedge, model the edge, compare after it.
  task automatic cyc(input logic t, input logic [3:0] c, input logic p, input logic s,
                     input string req);
    logic e;
    tick_en = t; rate_code = c; irq_enable = p; sqw_enable = s;
    e = 1'b0;
    if (t) begin
      mcnt = (mcnt + 1) % 32768;
      e = (c != 0) && (p || s) && ((mcnt % period_of(c)) == 0);
    end
    @(posedge clk); #2;
    if (e) pf_seen++;
    check(req, pf_pulse, e);
    check("R7", irq_pulse, e && p);
    check("R8", sqw_pulse, e && s);
    @(negedge clk);
  endtask

  initial begin
    #3_900_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    int unsigned first;
    seed = $urandom(32'd1234);
    // R1 reset state
    @(negedge clk); @(negedge clk);
    check("R1", pf_pulse, 1'b0);
    check("R1", irq_pulse, 1'b0);
    check("R1", sqw_pulse, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: code 0 quiet
    for (int i = 0; i < 300; i++) cyc(1'b1, 4'd0, 1'b1, 1'b1, "R2");
    // R5: enables off
    for (int i = 0; i < 300; i++) cyc(1'b1, 4'd3, 1'b0, 1'b0, "R5");
    // R3: code 3 and 6 periods
    for (int i = 0; i < 200; i++) cyc(1'b1, 4'd3, 1'b1, 1'b0, "R3");
    for (int i = 0; i < 400; i++) cyc(1'b1, 4'd6, 1'b0, 1'b1, "R3");
    // R4: aliased codes
    first = pf_seen;
    for (int i = 0; i < 1100; i++) cyc(1'b1, 4'd1, 1'b1, 1'b1, "R4");
    for (int i = 0; i < 1100; i++) cyc(1'b1, 4'd2, 1'b1, 1'b0, "R4");
    tests++;
    if (pf_seen - first < 8) begin
      fails++;
      $display("FAIL R4: actual %0d events expected >= 8", pf_seen - first);
    end
    // R9: sparse ticks, events only after tick edges
    for (int i = 0; i < 800; i++) cyc(($urandom % 3) == 0, 4'd3, 1'b1, 1'b1, "R9");
    // R10: change code mid-period
    for (int i = 0; i < 5; i++) cyc(1'b1, 4'd7, 1'b1, 1'b0, "R10");
    for (int i = 0; i < 300; i++) cyc(1'b1, 4'd4, 1'b1, 1'b0, "R10");
    // R3/R6: longest period through counter wrap
    for (int i = 0; i < 40000; i++) cyc(1'b1, 4'd15, 1'b1, 1'b1, "R6");
    // R6: random reprogramming keeps the phase
    for (int i = 0; i < 40000; i++) begin
      logic [3:0] c;
      c = 4'($urandom % 16);
      for (int k = 0; k < int'($urandom % 600) + 1; k++) begin
        cyc(($urandom % 8) != 0, c, 1'($urandom), 1'($urandom), "R6");
        i++;
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule